// File: doc/BRIEF.md
# Asynchronous CPU Bus Glue Controller

This block is the glue logic that sits between a 16-bit microprocessor with an asynchronous, strobe-qualified bus and its memories. It decodes the 23 word-address lines into three active-low chip selects: boot ROM, main RAM and one peripheral window. All decoding is qualified by the active-low address strobe. The upper and lower data strobes, together with the read/write line, become separate read and write enables for each byte lane.

A per-region wait-state timer drives the active-low data-transfer acknowledge. The timer is loaded when a bus cycle begins and counts down on the CPU clock. A write to the ROM region can be held off for a long programmable interval (about 50 ms at 50 MHz by default), so that an ordinary copy loop can program a slow electrically-writable ROM.

After reset the ROM is overlaid onto the low RAM window, so that the CPU reads its initial stack pointer and program counter from ROM at address zero. The overlay goes away on the first access to the ROM's home window and comes back only with the next reset. Unmapped addresses still receive an acknowledge, so the bus can never hang.

Top module: `cpu_bus_glue`

## Requirements
- R1: While `as_n` is high, every chip select, every lane enable and `dtack_n` are high (inactive). They follow `as_n` combinationally, with no clock edge needed.
- R2: With `as_n` low, the byte address {addr,0} selects exactly one region or none:
  - ROM for 0xF00000–0xFFFFFF;
  - the peripheral for 0xE00000–0xE0FFFF;
  - RAM for 0x000000–0x3FFFFF once the overlay is off;
  - nothing elsewhere.
- R3: After reset the overlay is on, and the window 0x000000–0x3FFFFF selects ROM instead of RAM. Any rising edge that samples `as_n` low with an address in 0xF00000–0xFFFFFF turns the overlay off. It stays off until `rst` is asserted again.
- R4: Read enables are active only while `as_n` is low, `rw`=1 (read) and a region is selected. `rd_hi_n` (D15..D8) follows `uds_n` and `rd_lo_n` (D7..D0) follows `lds_n`; both are active for a word access.
- R5: Write enables are active only while `as_n` is low, `rw`=0 (write) and a region is selected. `wr_hi_n` follows `uds_n` and `wr_lo_n` follows `lds_n`. No write enable is ever active while `rw`=1.
- R6: The first rising edge that samples `as_n` low loads a wait count W, chosen by region and direction:
  - RAM uses RAM_WAIT (default 0);
  - a ROM read uses ROM_RD_WAIT (default 2);
  - a ROM write uses ROM_WR_WAIT (default 2,500,000);
  - the peripheral uses PER_WAIT (default 4);
  - an unmapped address uses NONE_WAIT (default 1).

  `dtack_n` goes low after the (W+1)-th rising edge that samples `as_n` low, and not before.
- R7: `dtack_n` stays low until `as_n` rises and is released combinationally at that moment. If `as_n` rises before the count has expired, the cycle is abandoned.
- R8: A new cycle that begins after `as_n` has been high for at least one rising edge reloads the full wait count. The previous cycle's acknowledge does not carry over.
- R9: While `rst` (synchronous, active high) is asserted, `dtack_n` is high and the overlay is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe (D15..D8), active low |
| lds_n | input | 1 | Lower data strobe (D7..D0), active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 23 | Word address, bits 23..1 of the byte address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| per_cs_n | output | 1 | Peripheral chip select, active low |
| rd_hi_n | output | 1 | Upper-lane read enable, active low |
| rd_lo_n | output | 1 | Lower-lane read enable, active low |
| wr_hi_n | output | 1 | Upper-lane write enable, active low |
| wr_lo_n | output | 1 | Lower-lane write enable, active low |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
The decoder is driven with addresses on both sides of every window edge. These include 0x3FFFFE against 0x400000, 0xE0FFFE against 0xE10000, and 0xEFFFFE against 0xF00000, which separates an off-by-one mask from a correct one. The same low address is read before and after the first ROM-home access, and again after a second reset; this tells a sticky overlay apart from one that clears too early or never comes back. Word, upper-only and lower-only strobes are applied in both directions, which exposes swapped lanes or writes leaking into reads. The timer is exercised in every region with both directions, with a cycle abandoned mid-count, and with back-to-back cycles separated by a single idle edge, so that a wrong load value, a stale acknowledge or a missing reload each shows as a shifted `dtack_n` edge.

// File: rtl/glue_pkg.sv
package glue_pkg;

    localparam int BYTE_AW = 24;
    typedef logic [BYTE_AW-1:0] baddr_t;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_RAM  = 2'd1,
        RG_ROM  = 2'd2,
        RG_PER  = 2'd3
    } region_e;

    typedef struct packed {
        logic rom;
        logic ram;
        logic per;
    } sel_t;

    localparam baddr_t ROM_BASE = 24'hF0_0000;
    localparam baddr_t ROM_MASK = 24'hF0_0000;
    localparam baddr_t PER_BASE = 24'hE0_0000;
    localparam baddr_t PER_MASK = 24'hFF_0000;
    localparam baddr_t RAM_BASE = 24'h00_0000;
    localparam baddr_t RAM_MASK = 24'hC0_0000;

    function automatic logic hit(input baddr_t a, input baddr_t base, input baddr_t mask);
        return (a & mask) == base;
    endfunction

    function automatic region_e classify(input baddr_t a, input logic overlay);
        if (hit(a, ROM_BASE, ROM_MASK))      return RG_ROM;
        else if (hit(a, PER_BASE, PER_MASK)) return RG_PER;
        else if (hit(a, RAM_BASE, RAM_MASK)) return overlay ? RG_ROM : RG_RAM;
        else                                 return RG_NONE;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/glue_decoder.sv
module glue_decoder
    import glue_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         as_n,
    input  logic [23:1]  addr,
    input  logic         overlay,
    output sel_t         sel,
    output region_e      region,
    output logic         home_hit
);
    baddr_t byte_addr;
    assign byte_addr = {addr, 1'b0};

    always_comb begin
        region = classify(byte_addr, overlay);
        sel    = '0;
        if (!as_n) begin
            unique case (region)
                RG_ROM:  sel.rom = 1'b1;
                RG_RAM:  sel.ram = 1'b1;
                RG_PER:  sel.per = 1'b1;
                default: sel     = '0;
            endcase
        end
    end

    assign home_hit = !as_n && hit(byte_addr, ROM_BASE, ROM_MASK);

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (sel == '0));

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.rom, sel.ram, sel.per}));

endmodule

// File: rtl/glue_lanes.sv
module glue_lanes (
    input  logic clk,
    input  logic rst,
    input  logic as_n,
    input  logic uds_n,
    input  logic lds_n,
    input  logic rw,
    input  logic any_sel,
    output logic rd_hi_n,
    output logic rd_lo_n,
    output logic wr_hi_n,
    output logic wr_lo_n
);
    logic live, rd_ok, wr_ok;

    assign live  = !as_n && any_sel;
    assign rd_ok = live && rw;
    assign wr_ok = live && !rw;

    assign rd_hi_n = !(rd_ok && !uds_n);
    assign rd_lo_n = !(rd_ok && !lds_n);
    assign wr_hi_n = !(wr_ok && !uds_n);
    assign wr_lo_n = !(wr_ok && !lds_n);

    // R5
    no_write_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        rw |-> (wr_hi_n && wr_lo_n));

    // R4
    no_read_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        !rw |-> (rd_hi_n && rd_lo_n));

endmodule

// File: rtl/glue_dtack_timer.sv
module glue_dtack_timer
    import glue_pkg::*;
#(
    parameter int RAM_WAIT    = 0,
    parameter int ROM_RD_WAIT = 2,
    parameter int ROM_WR_WAIT = 2_500_000,
    parameter int PER_WAIT    = 4,
    parameter int NONE_WAIT   = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    as_n,
    input  logic    rw,
    input  region_e region,
    output logic    dtack_n
);
    localparam int MAXW = max_of(max_of(max_of(RAM_WAIT, ROM_RD_WAIT),
                                        max_of(ROM_WR_WAIT, PER_WAIT)), NONE_WAIT);
    localparam int CW   = (MAXW < 1) ? 1 : $clog2(MAXW + 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (region)
            RG_RAM:  load_val = CW'(RAM_WAIT);
            RG_ROM:  load_val = rw ? CW'(ROM_RD_WAIT) : CW'(ROM_WR_WAIT);
            RG_PER:  load_val = CW'(PER_WAIT);
            default: load_val = CW'(NONE_WAIT);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (as_n) begin
            active_q <= 1'b0;
        end else if (!active_q) begin
            active_q <= 1'b1;
            cnt_q    <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    assign dtack_n = !(active_q && (cnt_q == '0) && !as_n);

    // R7
    dtack_release_chk: assert property (@(posedge clk) disable iff (rst)
        as_n |-> dtack_n);

    // R6
    dtack_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (!as_n && $past(as_n)) |-> dtack_n);

endmodule

// File: rtl/cpu_bus_glue.sv
module cpu_bus_glue
    import glue_pkg::*;
#(
    parameter int RAM_WAIT    = 0,
    parameter int ROM_RD_WAIT = 2,
    parameter int ROM_WR_WAIT = 2_500_000,
    parameter int PER_WAIT    = 4,
    parameter int NONE_WAIT   = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        as_n,
    input  logic        uds_n,
    input  logic        lds_n,
    input  logic        rw,
    input  logic [23:1] addr,
    output logic        rom_cs_n,
    output logic        ram_cs_n,
    output logic        per_cs_n,
    output logic        rd_hi_n,
    output logic        rd_lo_n,
    output logic        wr_hi_n,
    output logic        wr_lo_n,
    output logic        dtack_n
);
    logic    overlay_q;
    sel_t    sel;
    region_e region;
    logic    home_hit;

    // R3: overlay set by reset, cleared by first ROM-home access
    always_ff @(posedge clk) begin
        if (rst)           overlay_q <= 1'b1;
        else if (home_hit) overlay_q <= 1'b0;
    end

    glue_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .as_n     (as_n),
        .addr     (addr),
        .overlay  (overlay_q),
        .sel      (sel),
        .region   (region),
        .home_hit (home_hit)
    );

    glue_lanes u_lanes (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .uds_n   (uds_n),
        .lds_n   (lds_n),
        .rw      (rw),
        .any_sel (|sel),
        .rd_hi_n (rd_hi_n),
        .rd_lo_n (rd_lo_n),
        .wr_hi_n (wr_hi_n),
        .wr_lo_n (wr_lo_n)
    );

    glue_dtack_timer #(
        .RAM_WAIT    (RAM_WAIT),
        .ROM_RD_WAIT (ROM_RD_WAIT),
        .ROM_WR_WAIT (ROM_WR_WAIT),
        .PER_WAIT    (PER_WAIT),
        .NONE_WAIT   (NONE_WAIT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .rw      (rw),
        .region  (region),
        .dtack_n (dtack_n)
    );

    assign rom_cs_n = !sel.rom;
    assign ram_cs_n = !sel.ram;
    assign per_cs_n = !sel.per;

    // R3
    overlay_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !overlay_q |=> !overlay_q);

    // R9
    reset_overlay_chk: assert property (@(posedge clk)
        rst |=> overlay_q);

endmodule

// File: tb/cpu_bus_glue_tb.sv
module cpu_bus_glue_tb;
    localparam int P_RAM = 0, P_ROMR = 2, P_ROMW = 40, P_PER = 4, P_NONE = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
    logic [23:1] addr = '0;
    logic rom_cs_n, ram_cs_n, per_cs_n, rd_hi_n, rd_lo_n, wr_hi_n, wr_lo_n, dtack_n;

    int checks = 0, fails = 0;
    bit bb_flag = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpu_bus_glue #(
        .RAM_WAIT(P_RAM), .ROM_RD_WAIT(P_ROMR), .ROM_WR_WAIT(P_ROMW),
        .PER_WAIT(P_PER), .NONE_WAIT(P_NONE)
    ) u_dut (
        .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
        .addr(addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .per_cs_n(per_cs_n),
        .rd_hi_n(rd_hi_n), .rd_lo_n(rd_lo_n), .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n),
        .dtack_n(dtack_n)
    );

    // reference model state
    bit m_overlay = 1;
    bit m_active  = 0;
    int m_left    = 0;

    // 0 none, 1 ram, 2 rom, 3 peripheral
    function automatic int region_of(int b, bit ovl);
        if (b >= 'hF00000) return 2;
        if (b >= 'hE00000 && b <= 'hE0FFFF) return 3;
        if (b <= 'h3FFFFF) return ovl ? 2 : 1;
        return 0;
    endfunction

    function automatic int wait_of(int rg, bit rd);
        case (rg)
            1: return P_RAM;
            2: return rd ? P_ROMR : P_ROMW;
            3: return P_PER;
            default: return P_NONE;
        endcase
    endfunction

    task automatic cmp(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        int  b  = {addr, 1'b0};
        int  rg = region_of(b, m_overlay);
        bit  on = !as_n;
        bit  sel = on && rg != 0;
        string cs_tag = rst ? "R9" : (!on ? "R1" : (b <= 'h3FFFFF ? "R3" : "R2"));
        string dt_tag = rst ? "R9" : (!on ? "R7" : (bb_flag ? "R8" : "R6"));
        cmp(cs_tag, "rom_cs_n", rom_cs_n, !(on && rg == 2));
        cmp(cs_tag, "ram_cs_n", ram_cs_n, !(on && rg == 1));
        cmp(cs_tag, "per_cs_n", per_cs_n, !(on && rg == 3));
        cmp(on ? "R4" : "R1", "rd_hi_n", rd_hi_n, !(sel && rw && !uds_n));
        cmp(on ? "R4" : "R1", "rd_lo_n", rd_lo_n, !(sel && rw && !lds_n));
        cmp(on ? "R5" : "R1", "wr_hi_n", wr_hi_n, !(sel && !rw && !uds_n));
        cmp(on ? "R5" : "R1", "wr_lo_n", wr_lo_n, !(sel && !rw && !lds_n));
        cmp(dt_tag, "dtack_n", dtack_n, !(on && m_active && m_left == 0));
    endtask

    task automatic model_edge();
        int b = {addr, 1'b0};
        if (rst) begin
            m_overlay = 1; m_active = 0; m_left = 0;
        end else if (as_n) begin
            m_active = 0;
        end else begin
            if (!m_active) begin
                m_active = 1;
                m_left = wait_of(region_of(b, m_overlay), rw);
            end else if (m_left > 0) begin
                m_left--;
            end
            if (b >= 'hF00000) m_overlay = 0;
        end
    endtask

    // compare shortly before every rising edge, then advance the model
    always begin
        @(negedge clk);
        #8;
        if (!done) begin
            check_all();
            model_edge();
        end
    end

    task automatic cycle(int b, bit rd, bit u, bit l, int hold);
        @(negedge clk);
        addr = b[23:1]; rw = rd; uds_n = !u; lds_n = !l; as_n = 1'b0;
        repeat (hold) @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rw = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R6) got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);                                 // R9 reset state checked
        @(negedge clk); rst = 1'b0;
        idle(2);
        cycle('h000000, 1, 1, 1, 5);             // R3 overlay: ROM at zero
        idle(1);
        cycle('h000002, 1, 1, 0, 5);             // R3/R4 upper lane only
        idle(1);
        cycle('h001000, 0, 1, 1, P_ROMW + 4);    // R3 overlaid ROM write, long hold R6
        idle(1);
        cycle('h3FFFFE, 1, 0, 1, 5);             // R3 window top, lower lane
        idle(1);
        cycle('hF00000, 1, 1, 1, 6);             // R3 clear overlay, R6 ROM read
        idle(1);
        cycle('h000000, 1, 1, 1, 3);             // R2 now RAM
        idle(1);
        cycle('h000010, 0, 1, 1, 3);             // R5 word write
        idle(1);
        cycle('h000012, 0, 1, 0, 3);             // R5 upper write
        idle(1);
        cycle('h000014, 0, 0, 1, 3);             // R5 lower write
        idle(1);
        cycle('h3FFFFE, 1, 1, 1, 3);             // R2 RAM top
        cycle('h400000, 1, 1, 1, 4);             // R2 unmapped, still acked
        idle(1);
        cycle('hE00010, 1, 1, 1, 7);             // R2 peripheral read
        idle(1);
        cycle('hE0FFFE, 0, 1, 1, 7);             // R2 peripheral top, write
        idle(1);
        cycle('hE10000, 1, 1, 1, 4);             // R2 just past peripheral
        idle(1);
        cycle('hEFFFFE, 0, 0, 1, 4);             // R2 below ROM, unmapped
        idle(1);
        cycle('hFFFFFE, 1, 1, 1, 5);             // R2 ROM top
        idle(1);
        cycle('hF00100, 0, 1, 1, P_ROMW + 4);    // R6 slow ROM write
        idle(1);
        cycle('hE00000, 1, 1, 1, 2);             // R7 abandoned mid-count
        idle(1);
        bb_flag = 1;                             // R8 back-to-back
        cycle('hE00020, 1, 1, 1, 6);
        cycle('hF00004, 1, 1, 1, 5);
        cycle('h000100, 1, 1, 1, 2);
        cycle('hE00030, 0, 0, 1, 7);
        bb_flag = 0;
        idle(1);
        @(negedge clk); rst = 1'b1;              // R9 second reset
        idle(2);
        @(negedge clk); rst = 1'b0;
        idle(1);
        cycle('h000000, 1, 1, 1, 5);             // R3 overlay restored
        idle(3);
        finish_run();
    end
endmodule